// File: doc/BRIEF.md
# Butterfly / Inverse-Butterfly Bit Permuter

This block rearranges the bits of a 64-bit word through six exchange stages. Each stage groups the word into 32 bit pairs a fixed distance apart, and one control bit per pair decides whether the two bits trade places or stay where they are. Six 32-bit control slices drive the whole network. A mode input selects the stage order. In forward (butterfly) order the pair distance starts at 32 and halves on each stage down to 1. In inverse order the distance starts at 1 and doubles up to 32.

Two passes in a row, first forward and then inverse, form a Benes network, which can reach any of the 64! bit orderings. Software or a separate routing engine works out the control words; this block only applies them. The permuted word is registered once, so a result appears on the output one clock after its operands are presented.

Top module: `bfly_permuter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `perm_out` becomes all zeros on that edge.
- R2: `perm_out` shows the permutation of the `word_in`, `swap_ctrl` and `inverse` values sampled at the previous rising edge, and keeps its value between edges.
- R3: An all-zero `swap_ctrl` makes `perm_out` equal to `word_in` in both modes.
- R4: With `inverse` = 0, control slice s (`swap_ctrl[32*s +: 32]`, s = 0..5) drives the stage applied s-th, and that stage pairs bits 32>>s apart (32, 16, 8, 4, 2, 1).
- R5: With `inverse` = 1, control slice s drives the stage applied s-th, and that stage pairs bits 1<<s apart (1, 2, 4, 8, 16, 32).
- R6: Inside a slice, bit p controls the p-th pair when the pairs of that stage are sorted by the index of their lower bit. A value of 1 swaps the pair and 0 leaves it in place.
- R7: The output always holds the same number of 1 bits as the input it came from.
- R8: A forward pass with controls C, followed by an inverse pass whose slice s equals slice 5-s of C, gives back the original word.
- R9: For any data and controls, the output matches the stage-by-stage composition of R4 to R6 in either mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| word_in | input | 64 | Data word to permute |
| swap_ctrl | input | 192 | Six 32-bit swap slices; slice s sits at bits 32*s+31..32*s |
| inverse | input | 1 | 0 = butterfly order, 1 = inverse-butterfly order |
| perm_out | output | 64 | Registered permuted word |

## Verification
The clocked checks look only at cycles whose previous edge was already out of reset. They assume that `word_in`, `swap_ctrl` and `inverse` were 2-state values at that edge. The bench therefore drives every input to a defined value before reset is released and changes them only on falling edges. The stage-level checks assume each stage's input word is fully known. This follows from the same rule, because the data and the controls are never left undriven.

// File: rtl/bfly_pkg.sv
// Package: shared sizing and the stage-distance rule for the bit permuter.
// Assumes: word width is a power of two, at least 2.
package bfly_pkg;
    parameter int BFLY_WIDTH = 64;

    // Pair distance of the k-th applied stage, for either stage order.
    function automatic int stage_dist(input int width, input int k, input bit rev);
        if (rev)
            return 1 << k;
        else
            return width >> (k + 1);
    endfunction
endpackage

// File: rtl/bfly_stage.sv
// Module: one exchange stage. It pairs bits DIST apart and swaps a pair
// when that pair's control bit is 1. Pair p is the p-th pair ordered by its
// lower bit index.
// Assumes: W is a power of two and DIST is a power of two below W.
module bfly_stage #(
    parameter int W    = 64,
    parameter int DIST = 32
) (
    input  logic [W-1:0]   din,
    input  logic [W/2-1:0] swap,
    output logic [W-1:0]   dout
);
    localparam int SH = $clog2(DIST);

    genvar p;
    generate
        for (p = 0; p < W/2; p++) begin : g_pair
            localparam int LO = ((p >> SH) << (SH + 1)) | (p & (DIST - 1));
            localparam int HI = LO + DIST;
            // Exchange cell: either cross or keep the two bits of this pair.
            assign dout[LO] = swap[p] ? din[HI] : din[LO];
            assign dout[HI] = swap[p] ? din[LO] : din[HI];
        end
    endgenerate

    // Stage-local checks: no bit is lost and zero control passes straight through.
    always_comb begin
        assert_stage_weight_R7: assert ($countones(dout) == $countones(din));
        if (swap == '0) begin
            assert_stage_pass_R3: assert (dout == din);
        end
    end
endmodule

// File: rtl/bfly_chain.sv
// Module: a cascade of log2(W) exchange stages in one fixed order.
// REV = 0 gives distances W/2 down to 1; REV = 1 gives 1 up to W/2.
// Control slice s always drives the s-th stage the data passes through.
module bfly_chain
    import bfly_pkg::*;
#(
    parameter int W   = 64,
    parameter bit REV = 1'b0
) (
    input  logic [W-1:0]                din,
    input  logic [$clog2(W)*(W/2)-1:0] ctrl,
    output logic [W-1:0]                dout
);
    localparam int STAGES = $clog2(W);
    localparam int HALF   = W / 2;

    logic [W-1:0] lvl [0:STAGES];

    assign lvl[0] = din;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            bfly_stage #(
                .W    (W),
                .DIST (stage_dist(W, s, REV))
            ) stage_i (
                .din  (lvl[s]),
                .swap (ctrl[s*HALF +: HALF]),
                .dout (lvl[s+1])
            );
        end
    endgenerate

    assign dout = lvl[STAGES];
endmodule

// File: rtl/bfly_permuter.sv
// Module: top of the permuter. It builds a forward and an inverse exchange
// chain, picks one by mode, and registers the result once.
// Assumes: inputs are stable and 2-state at each rising edge.
module bfly_permuter
    import bfly_pkg::*;
#(
    parameter int W = BFLY_WIDTH
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [W-1:0]                word_in,
    input  logic [$clog2(W)*(W/2)-1:0] swap_ctrl,
    input  logic                        inverse,
    output logic [W-1:0]                perm_out
);
    logic [W-1:0] fwd_word;
    logic [W-1:0] inv_word;
    logic [W-1:0] sel_word;

    bfly_chain #(.W(W), .REV(1'b0)) fwd_i (
        .din  (word_in),
        .ctrl (swap_ctrl),
        .dout (fwd_word)
    );

    bfly_chain #(.W(W), .REV(1'b1)) inv_i (
        .din  (word_in),
        .ctrl (swap_ctrl),
        .dout (inv_word)
    );

    // Mode select between the two stage orders.
    always_comb begin
        sel_word = inverse ? inv_word : fwd_word;
    end

    // Output register with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            perm_out <= '0;
        else
            perm_out <= sel_word;
    end

    // Registered output keeps the bit weight of the word sampled one edge earlier.
    assert_out_weight_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $countones(perm_out) == $countones($past(word_in)));

    // Zero control sampled at the last edge reproduces the sampled word.
    assert_out_identity_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(swap_ctrl) == '0) |-> perm_out == $past(word_in));

    // Unchanged operands across an edge leave the output unchanged (R2).
    assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(word_in) && $stable(swap_ctrl) && $stable(inverse))
        |=> $stable(perm_out));
endmodule

// File: tb/bfly_permuter_tb.sv
module bfly_permuter_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  word_in = '0;
    logic [191:0] swap_ctrl = '0;
    logic         inverse = 1'b0;
    logic [63:0]  perm_out;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bfly_permuter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .word_in   (word_in),
        .swap_ctrl (swap_ctrl),
        .inverse   (inverse),
        .perm_out  (perm_out)
    );

    // Reference: apply stages one by one; the pair index is the lower index with the distance bit removed.
    function automatic logic [63:0] model(input logic [63:0] x, input logic [191:0] c, input bit inv);
        logic [63:0] y;
        for (int s = 0; s < 6; s++) begin
            int k = inv ? s : 5 - s;
            int d = 1 << k;
            y = x;
            for (int i = 0; i < 64; i++) begin
                if ((i & d) == 0) begin
                    int p = ((i >> (k + 1)) << k) | (i & (d - 1));
                    if (c[s*32 + p]) begin
                        y[i]     = x[i + d];
                        y[i + d] = x[i];
                    end
                end
            end
            x = y;
        end
        return x;
    endfunction

    function automatic logic [191:0] rev_slices(input logic [191:0] c);
        logic [191:0] r;
        for (int s = 0; s < 6; s++) r[s*32 +: 32] = c[(5 - s)*32 +: 32];
        return r;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // Drive on a falling edge, let one rising edge register it, sample at the next falling edge.
    task automatic apply(input logic [63:0] d, input logic [191:0] c, input bit inv);
        word_in = d;
        swap_ctrl = c;
        inverse = inv;
        @(negedge clk);
    endtask

    task automatic test_reset;
        check("R1", perm_out, 64'h0);
    endtask

    task automatic test_latency;
        apply(64'h0123_4567_89AB_CDEF, '0, 1'b0);
        word_in = 64'hFFFF_0000_FFFF_0000;
        #1;
        check("R2", perm_out, 64'h0123_4567_89AB_CDEF);
        @(negedge clk);
        check("R2", perm_out, 64'hFFFF_0000_FFFF_0000);
        @(negedge clk);
        check("R2", perm_out, 64'hFFFF_0000_FFFF_0000);
    endtask

    task automatic test_identity;
        apply(64'hDEAD_BEEF_CAFE_F00D, '0, 1'b0);
        check("R3", perm_out, 64'hDEAD_BEEF_CAFE_F00D);
        apply(64'h8000_0000_0000_0001, '0, 1'b1);
        check("R3", perm_out, 64'h8000_0000_0000_0001);
    endtask

    // One control bit set: the single 1 bit moves from the lower to the upper pair position.
    task automatic test_single_swaps(input bit inv);
        int pairs [3] = '{0, 13, 31};
        for (int s = 0; s < 6; s++) begin
            int d = inv ? (1 << s) : (32 >> s);
            foreach (pairs[j]) begin
                int p = pairs[j];
                int lo = (p / d) * 2 * d + (p % d);
                logic [191:0] c = '0;
                c[s*32 + p] = 1'b1;
                apply(64'h1 << lo, c, inv);
                check(inv ? "R5/R6" : "R4/R6", perm_out, 64'h1 << (lo + d));
                apply(64'h1 << (lo + d), c, inv);
                check(inv ? "R5/R6" : "R4/R6", perm_out, 64'h1 << lo);
            end
        end
    endtask

    task automatic test_random;
        for (int n = 0; n < 200; n++) begin
            logic [63:0]  d = {$urandom(), $urandom()};
            logic [191:0] c = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
            bit inv = n[0];
            apply(d, c, inv);
            check("R9", perm_out, model(d, c, inv));
            n_checks++;
            if ($countones(perm_out) != $countones(d)) begin
                n_fail++;
                $display("FAIL R7: weight %0d expected %0d", $countones(perm_out), $countones(d));
            end
        end
    endtask

    task automatic test_roundtrip;
        for (int n = 0; n < 50; n++) begin
            logic [63:0]  d = {$urandom(), $urandom()};
            logic [191:0] c = {$urandom(), $urandom(), $urandom(), $urandom(), $urandom(), $urandom()};
            logic [63:0]  mid;
            apply(d, c, 1'b0);
            mid = perm_out;
            apply(mid, rev_slices(c), 1'b1);
            check("R8", perm_out, d);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_latency();
        test_identity();
        test_single_swaps(1'b0);
        test_single_swaps(1'b1);
        test_random();
        test_roundtrip();
        rst_n = 1'b0;
        word_in = 64'hFFFF_FFFF_FFFF_FFFF;
        @(negedge clk);
        test_reset();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule